// File: doc/BRIEF.md
# Buffered Flash Program Engine

This block runs the buffered-program sequence of a parallel flash controller. Once the command sequencer has accepted the buffered-program opcode (0xE8) it pulses `startPulse`, and every later write on the shared write port goes to this engine. The first write supplies a word count. The next count+1 writes are data. They are staged privately against one aligned write block of the array and do not touch it. A final confirm write then either commits the staged words to the array or discards them all.

A commit is atomic from the array's point of view. The array sees nothing until the confirm code arrives with no program error recorded. The commit then sweeps the whole block, one word per clock, and writes back only the words that were staged. A per-word mask stands in for a full snapshot copy: a word that was never staged keeps its array value, which gives the same result as reading it into the buffer and writing it back. The sequencer owns the status register. It ORs in `readySet` (ready bit) and `progErrSet` (bit 4), and returns its bit 4 as `errIn`.

Top module: `wbuf_engine`

## Requirements
- R1: After reset the engine is idle: `seqActive`, `copyBusy` and `arrWe` are 0.
- R2: The count write keeps only its low DEV_BYTES bytes, or its low BANK_BYTES bytes when DEV_BYTES is 0. With the defaults (2-byte bank, 1-byte devices), a count of 0x0102 is taken as 2.
- R3: A kept count of N admits exactly N+1 data writes. The next write is treated as the confirm write and is never stored as data.
- R4: The write block holds (BANK_BYTES==1 ? 256 : 2048) × (BANK_BYTES/DEV_BYTES) bytes, which is 2048 16-bit words by default. The first data write fixes the staged block as its word address aligned down to that size, and the commit sweep starts at that base.
- R5: A data write whose address lies outside the staged block asserts `progErrSet` in the same cycle and is dropped.
- R6: Every data write asserts `readySet` in its cycle. While `writeProtect` is 1, a data write asserts `progErrSet` and is not staged.
- R7: A confirm write whose low byte is 0xD0 is a commit when no program error was flagged in this sequence and `errIn` is 0. A commit holds `copyBusy` for exactly one block of cycles, stepping `arrAddr` from the base one word per clock, and writes only the staged words. `doneCycle0` pulses in the last copy cycle.
- R8: Any other confirm value, or a pending error, pulses `abortToRead` and discards the staged data. No array write follows and the engine returns to idle.
- R9: When the same word is written twice in one sequence, the later data is the data committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Buffered-program opcode accepted; engage the engine |
| wrValid | input | 1 | A write from the sequencer is present this cycle |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | 8*BANK_BYTES | Write data (count, data word or confirm code) |
| writeProtect | input | 1 | Array is write-protected |
| errIn | input | 1 | Program-error bit currently held in the status register |
| seqActive | output | 1 | Engine is inside a buffered-program sequence |
| copyBusy | output | 1 | Commit copy in progress |
| readySet | output | 1 | Set the ready bit this cycle |
| progErrSet | output | 1 | Set the program-error bit this cycle |
| abortToRead | output | 1 | Sequence discarded; sequencer returns to read-array mode |
| doneCycle0 | output | 1 | Commit finishes; sequencer returns to cycle 0 |
| arrWe | output | 1 | Array write enable |
| arrAddr | output | ADDR_W | Array word address |
| arrData | output | 8*BANK_BYTES | Array write data |

## Verification
`readySet`, `progErrSet` and `abortToRead` are combinational on the write being offered, so they are due in the same cycle as that write. The bench samples them one time step after driving the inputs at the falling edge. Copy activity starts on the clock edge that takes the confirm write, so the first falling edge after that edge already shows `copyBusy` and the base address. From there the bench counts falling edges until `copyBusy` drops. Array contents are compared only after the copy has drained, against a shadow image that the bench updates from the requirements.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_COPY
  } wbState_e;

  // strobes from control to staging datapath
  typedef struct packed {
    logic claimBlock;
    logic storeWord;
    logic dropAll;
  } wbStrobe_t;

  localparam logic [7:0] CONFIRM_CODE = 8'hD0;
endpackage

// File: rtl/wbuf_stage.sv
module wbuf_stage
  import wbuf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              copying,
  input  logic [OFF_W-1:0]  copyIdx,
  output logic              stageValid,
  output logic              inBlock,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [WORD_W-1:0] arrData
);
  localparam int BLOCK_WORDS = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0]       baseTag;
  logic [BLOCK_WORDS-1:0] stagedMask;
  logic [WORD_W-1:0]      stageMem [BLOCK_WORDS];

  wire [OFF_W-1:0] wrOff = wrAddr[OFF_W-1:0];
  wire [TAG_W-1:0] wrTag = wrAddr[ADDR_W-1:OFF_W];

  // before the block is claimed the first write defines it, so it is inside
  assign inBlock = stageValid ? (wrTag == baseTag) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      baseTag    <= '0;
      stagedMask <= '0;
    end else if (strobe.dropAll) begin
      stageValid <= 1'b0;
      stagedMask <= '0;
    end else begin
      if (strobe.claimBlock) begin
        stageValid <= 1'b1;
        baseTag    <= wrTag;
        stagedMask <= '0;
      end
      if (strobe.storeWord) stagedMask[wrOff] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeWord) stageMem[wrOff] <= wrData;
  end

  assign arrWe   = copying & stagedMask[copyIdx];
  assign arrAddr = {baseTag, copyIdx};
  assign arrData = stageMem[copyIdx];
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             wrValid,
  input  logic [CNT_W-1:0] cntData,
  input  logic [7:0]       codeByte,
  input  logic             writeProtect,
  input  logic             errIn,
  input  logic             stageValid,
  input  logic             inBlock,
  output wbStrobe_t        strobe,
  output logic             copying,
  output logic [OFF_W-1:0] copyIdx,
  output logic             seqActive,
  output logic             readySet,
  output logic             progErrSet,
  output logic             abortToRead,
  output logic             doneCycle0
);
  wbState_e         state;
  logic [CNT_W-1:0] remain;
  logic             errSeen;

  logic dataCyc, confirmCyc, goCommit, lastIdx;

  always_comb begin
    dataCyc     = (state == ST_DATA) && wrValid;
    confirmCyc  = (state == ST_CONFIRM) && wrValid;
    lastIdx     = &copyIdx;
    copying     = (state == ST_COPY);
    seqActive   = (state != ST_IDLE);
    progErrSet  = dataCyc && (writeProtect || !inBlock);
    goCommit    = confirmCyc && (codeByte == CONFIRM_CODE) && !errIn
                  && !errSeen && stageValid;
    abortToRead = confirmCyc && !goCommit;
    doneCycle0  = copying && lastIdx;
    readySet    = dataCyc || doneCycle0;
    strobe.claimBlock = dataCyc && !stageValid;
    strobe.storeWord  = dataCyc && !writeProtect && inBlock;
    strobe.dropAll    = abortToRead || doneCycle0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remain  <= '0;
      copyIdx <= '0;
      errSeen <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (startPulse) begin
          state   <= ST_COUNT;
          errSeen <= 1'b0;
        end
        ST_COUNT: if (wrValid) begin
          remain <= cntData;
          state  <= ST_DATA;
        end
        ST_DATA: if (wrValid) begin
          if (progErrSet) errSeen <= 1'b1;
          if (remain == '0) state <= ST_CONFIRM;
          else remain <= remain - 1'b1;
        end
        ST_CONFIRM: if (wrValid) begin
          copyIdx <= '0;
          state   <= goCommit ? ST_COPY : ST_IDLE;
        end
        ST_COPY: begin
          copyIdx <= copyIdx + 1'b1;
          if (lastIdx) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbuf_engine.sv
module wbuf_engine
  import wbuf_pkg::*;
#(
  parameter int BANK_BYTES = 2,
  parameter int DEV_BYTES  = 1,
  parameter int ADDR_W     = 12,
  localparam int WORD_W    = 8 * BANK_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              writeProtect,
  input  logic              errIn,
  output logic              seqActive,
  output logic              copyBusy,
  output logic              readySet,
  output logic              progErrSet,
  output logic              abortToRead,
  output logic              doneCycle0,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [WORD_W-1:0] arrData
);
  localparam int NUM_DEV     = (DEV_BYTES == 0) ? 1 : BANK_BYTES / DEV_BYTES;
  localparam int BLOCK_BYTES = ((BANK_BYTES == 1) ? 256 : 2048) * NUM_DEV;
  localparam int BLOCK_WORDS = BLOCK_BYTES / BANK_BYTES;
  localparam int OFF_W       = $clog2(BLOCK_WORDS);
  localparam int KEEP_BYTES  = (DEV_BYTES == 0) ? BANK_BYTES : DEV_BYTES;
  localparam int CNT_W       = 8 * KEEP_BYTES;

  wbStrobe_t        strobe;
  logic             stageValid, inBlock;
  logic [OFF_W-1:0] copyIdx;

  wbuf_ctrl #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .wrValid(wrValid),
    .cntData(wrData[CNT_W-1:0]), .codeByte(wrData[7:0]),
    .writeProtect(writeProtect), .errIn(errIn),
    .stageValid(stageValid), .inBlock(inBlock), .strobe(strobe),
    .copying(copyBusy), .copyIdx(copyIdx), .seqActive(seqActive),
    .readySet(readySet), .progErrSet(progErrSet),
    .abortToRead(abortToRead), .doneCycle0(doneCycle0)
  );

  wbuf_stage #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_stage (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .copying(copyBusy), .copyIdx(copyIdx),
    .stageValid(stageValid), .inBlock(inBlock), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrData(arrData)
  );
endmodule

// File: rtl/wbuf_engine_checker.sv
module wbuf_engine_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              seqActive,
  input logic              copyBusy,
  input logic              readySet,
  input logic              progErrSet,
  input logic              abortToRead,
  input logic              doneCycle0,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr
);
  // R1: copy activity only inside an engaged sequence
  p_copy_needs_seq_r1: assert property (@(posedge clk) disable iff (!rstN)
    copyBusy |-> seqActive);

  // R7: array written only during a commit sweep
  p_we_only_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> copyBusy);

  // R7: sweep advances one word per clock
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (copyBusy && $past(copyBusy)) |-> (arrAddr == $past(arrAddr) + 1'b1));

  // R7: completion pulse closes the sweep
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneCycle0 |=> !copyBusy);

  // R6: an error-flagged data write still reports ready
  p_err_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    progErrSet |-> (readySet && !copyBusy));

  // R8: an abort leaves the engine idle with no copy
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    abortToRead |=> (!seqActive && !copyBusy));
endmodule

bind wbuf_engine wbuf_engine_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .seqActive(seqActive), .copyBusy(copyBusy),
  .readySet(readySet), .progErrSet(progErrSet), .abortToRead(abortToRead),
  .doneCycle0(doneCycle0), .arrWe(arrWe), .arrAddr(arrAddr)
);

// File: tb/wbuf_engine_test.sv
`timescale 1ns/1ps
module wbuf_engine_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MEM_WORDS = 1 << AW;
  localparam int BLK = 2048; // (2048 bytes * 2 devices) / 2 bytes per word

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, wrValid = 1'b0, writeProtect = 1'b0, errIn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic seqActive, copyBusy, readySet, progErrSet, abortToRead, doneCycle0, arrWe;
  logic [AW-1:0] arrAddr;
  logic [DW-1:0] arrData;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [DW-1:0] arrMem [MEM_WORDS];
  logic [DW-1:0] expMem [MEM_WORDS];

  always #2 clk = ~clk;

  wbuf_engine uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .writeProtect(writeProtect),
    .errIn(errIn), .seqActive(seqActive), .copyBusy(copyBusy),
    .readySet(readySet), .progErrSet(progErrSet), .abortToRead(abortToRead),
    .doneCycle0(doneCycle0), .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

  function automatic logic [DW-1:0] seed(int i);
    return DW'(i * 16'h02F1) ^ 16'hA5C3;
  endfunction

  // array model: filled during reset, written through the engine's port
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) arrMem[i] <= seed(i);
    end else if (arrWe) begin
      arrMem[arrAddr] <= arrData;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic startSeq();
    @(negedge clk); startPulse = 1'b1;
    @(posedge clk); #1 startPulse = 1'b0;
  endtask

  // one write; combinational responses captured before the edge
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output bit rdy, output bit err, output bit ab);
    @(negedge clk); wrValid = 1'b1; wrAddr = a; wrData = d;
    #1 rdy = readySet; err = progErrSet; ab = abortToRead;
    @(posedge clk); #1 wrValid = 1'b0;
  endtask

  task automatic waitCopy(output int cyc, output int dones, output logic [AW-1:0] first);
    cyc = 0; dones = 0; first = '0;
    @(negedge clk);
    while (copyBusy && cyc < 5000) begin
      if (cyc == 0) first = arrAddr;
      if (doneCycle0) dones++;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic compareArr(input string req);
    int bad = 0; int firstBad = -1;
    for (int i = 0; i < MEM_WORDS; i++)
      if (arrMem[i] !== expMem[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    check(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first mismatch word 0x%0h", firstBad);
  endtask

  // a committed sequence; expMem is updated in staged order (last write wins)
  task automatic commitSeq(input logic [DW-1:0] cnt, input int n,
                           input logic [AW-1:0] addrs[], input logic [DW-1:0] datas[],
                           input logic [AW-1:0] base, input string tag);
    bit rdy, err, ab; int cyc, dones; logic [AW-1:0] first;
    int rdyBad = 0, errBad = 0;
    startSeq();
    doWrite('0, cnt, rdy, err, ab);
    for (int k = 0; k < n; k++) begin
      doWrite(addrs[k], datas[k], rdy, err, ab);
      if (!rdy) rdyBad++;
      if (err) errBad++;
      expMem[addrs[k]] = datas[k];
    end
    check(rdyBad == 0, {"R6 ready per data write ", tag}, rdyBad, 0);
    check(errBad == 0, {"R5 no error inside block ", tag}, errBad, 0);
    check(seqActive && !copyBusy, {"R3 waits for confirm ", tag}, {seqActive, copyBusy}, 2'b10);
    doWrite('0, 16'h37D0, rdy, err, ab);
    check(!ab, {"R7 confirm accepted ", tag}, ab, 0);
    waitCopy(cyc, dones, first);
    check(cyc == BLK, {"R7 copy length ", tag}, cyc, BLK);
    check(dones == 1, {"R7 single done pulse ", tag}, dones, 1);
    check(first == base, {"R4 sweep base ", tag}, first, base);
    compareArr({"R7 array after commit ", tag});
  endtask

  task automatic abortSeq(input logic [DW-1:0] cnt, input int n,
                          input logic [AW-1:0] addrs[], input logic [DW-1:0] datas[],
                          input logic [DW-1:0] code, input int errAt, input string tag);
    bit rdy, err, ab; int cyc, dones; logic [AW-1:0] first;
    startSeq();
    doWrite('0, cnt, rdy, err, ab);
    for (int k = 0; k < n; k++) begin
      doWrite(addrs[k], datas[k], rdy, err, ab);
      check(rdy, {"R6 ready ", tag}, rdy, 1);
      check(err == (k == errAt), {"R5 R6 error flag ", tag}, err, (k == errAt));
    end
    doWrite('0, code, rdy, err, ab);
    check(ab, {"R8 abort pulse ", tag}, ab, 1);
    waitCopy(cyc, dones, first);
    check(cyc == 0 && !seqActive, {"R8 no copy, idle ", tag}, cyc, 0);
    compareArr({"R8 array unchanged ", tag});
  endtask

  initial begin
    logic [AW-1:0] a[]; logic [DW-1:0] d[];
    for (int i = 0; i < MEM_WORDS; i++) expMem[i] = seed(i);
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!seqActive && !copyBusy && !arrWe, "R1 reset idle",
          {seqActive, copyBusy, arrWe}, 0);
    compareArr("R1 array untouched");

    // R2: 0x0102 keeps low byte 2 -> three data writes in block 1
    a = new[3]; d = new[3];
    a[0] = 12'h805; a[1] = 12'h806; a[2] = 12'hFFF;
    d[0] = 16'h1111; d[1] = 16'h2222; d[2] = 16'h3333;
    commitSeq(16'h0102, 3, a, d, 12'h800, "R2 count truncation");

    // R3: count 0 -> single write
    a = new[1]; d = new[1];
    a[0] = 12'h7FF; d[0] = 16'hBEEF;
    commitSeq(16'h0000, 1, a, d, 12'h000, "R3 count zero");

    // R9: repeated word, later data wins
    a = new[3]; d = new[3];
    a[0] = 12'h010; a[1] = 12'h010; a[2] = 12'h011;
    d[0] = 16'hAAAA; d[1] = 16'h5555; d[2] = 16'h0F0F;
    commitSeq(16'h0002, 3, a, d, 12'h000, "R9 overwrite");

    // R4: 256-write sweep across block 1, first address mid-block
    a = new[256]; d = new[256];
    for (int k = 0; k < 256; k++) begin
      a[k] = AW'(12'h803 + k * 7);
      d[k] = DW'(k * 16'h0123 + 16'h0042);
    end
    commitSeq(16'h00FF, 256, a, d, 12'h800, "R4 full count sweep");

    // R5: second write outside block 0
    a = new[2]; d = new[2];
    a[0] = 12'h100; a[1] = 12'h900; d[0] = 16'h1234; d[1] = 16'h4321;
    abortSeq(16'h0001, 2, a, d, 16'h00D0, 1, "R5 outside block");

    // R8: wrong confirm code
    a = new[1]; d = new[1];
    a[0] = 12'h020; d[0] = 16'h7777;
    abortSeq(16'h0000, 1, a, d, 16'h00FF, -1, "R8 bad code");

    // R8: error pending in status register
    errIn = 1'b1;
    abortSeq(16'h0000, 1, a, d, 16'h00D0, -1, "R8 errIn set");
    errIn = 1'b0;

    // R6: protected array
    writeProtect = 1'b1;
    abortSeq(16'h0000, 1, a, d, 16'h00D0, 0, "R6 write protect");
    writeProtect = 1'b0;

    // engine usable again after aborts
    a = new[1]; d = new[1];
    a[0] = 12'h020; d[0] = 16'h9999;
    commitSeq(16'h0000, 1, a, d, 12'h000, "R7 after aborts");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule